// File: doc/BRIEF.md
# Encrypted direct-mapped cache controller

The controller fronts a direct-mapped data cache whose contents never sit in the clear. Every word and every tag is scrambled before it reaches storage, and unscrambled on the way out. Scrambling uses a keyed transform whose mask depends on where the word lives, built from its set and word position. The transform is a placeholder for a real tweakable block cipher. It keeps the latencies the real one would have: six register stages that take a new word every cycle for storing, and three stages for recovery. A second three-stage recovery path, running beside the data path, reads back the stored tag for the hit comparison.

A requester presents one access at a time: an address, a read/write flag, byte enables and write data. It waits for `ready` to return and for a one-cycle response with the data word and a hit flag. On a miss the controller fetches a whole 256-bit line over a simple memory port. If the line being replaced was modified, the controller first recovers that line in plain form and writes it back. While a stored word is still travelling through the six scrambling stages, an access to that word is served from the value still in flight.

Top module: `enc_cache_ctrl`

## Requirements
- R1: The address splits as tag = addr[63:12], set = addr[11:5], word = addr[4:3]. The byte offset addr[2:0] has no effect on which 64-bit word is read or written.
- R2: After reset, `ready` is 1 and both `rsp_valid` and `mem_req` are 0. Every line is invalid, so the first access to any address misses and writes nothing back, even if that line was modified before the reset.
- R3: On a miss, `ready` stays low and a refill (`mem_req`=1, `mem_we`=0) is issued at {tag, set, 5'b0}. The single response then carries `rsp_hit`=0 and the requested word of the refilled line, where word w is `mem_rline[64w+63:64w]`.
- R4: On a hit, the response carries `rsp_hit`=1 and the most recently written value of the word, with no memory request.
- R5: In a write, `req_be[i]`=1 replaces bits [8i+7:8i] of the addressed word with the same bits of `req_wdata`, and the other bytes keep their value. The write response returns the merged word.
- R6: A read or partial write to a word whose earlier write is still in the six-stage scrambling pipeline uses the youngest pending value of that word.
- R7: A miss on a valid, modified line first writes the whole line back (`mem_req`=1, `mem_we`=1) at {old tag, set, 5'b0}, carrying plaintext words in the same lane order as a refill. Only then does the refill start.
- R8: A miss on a valid, unmodified line issues no write-back.
- R9: A write miss refills the line, then merges the write into it. The line is then modified and is written back when it is evicted.
- R10: Words at different word positions, and lines in different sets, keep independent values.
- R11: Once `mem_req` is raised, `mem_we`, `mem_addr` and `mem_wline` hold steady until a cycle with `mem_ack`=1. A refill captures `mem_rline` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken when `ready` is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 64 | Byte address |
| req_be | input | 8 | Byte enables for writes |
| req_wdata | input | 64 | Write data |
| ready | output | 1 | Controller can take a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Access hit on its first lookup |
| rsp_rdata | output | 64 | Word read, or merged word after a write |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | 64 | Line-aligned memory address |
| mem_wline | output | 256 | Write-back line data |
| mem_ack | input | 1 | Memory completes the transfer |
| mem_rline | input | 256 | Refill line data |

## Verification
Reads and writes run against a bench model of memory and of the cache's tag state. The patterns are cold misses, hits on other words of a freshly filled line, full and partial writes, and reads at non-zero byte offsets. Back-to-back accesses to a word whose write is still being scrambled can only return the right value if forwarding works. A double write followed by a read tells the youngest in-flight value apart from an older one. Conflict misses on modified and unmodified lines show whether a write-back happens, where it goes, and whether the plaintext it carries survives a later refill. A reset in the middle of the run shows that a previously modified line comes back as a clean miss.

// File: rtl/enc_cache_ctrl.sv
module enc_cache_ctrl #(
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 64,
  parameter int SETS    = 128,
  parameter int WORDS   = 4,
  parameter int ENC_LAT = 6,
  parameter int DEC_LAT = 3,
  parameter logic [DATA_W-1:0] KEY = DATA_W'(64'h3C6E_F372_FE94_F82B)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W/8-1:0]      req_be,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     ready,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W*WORDS-1:0]  mem_wline,
  input  logic                     mem_ack,
  input  logic [DATA_W*WORDS-1:0]  mem_rline
);
  localparam int BE_W   = DATA_W / 8;
  localparam int OFF_W  = $clog2(BE_W);
  localparam int SET_W  = $clog2(SETS);
  localparam int WRD_W  = $clog2(WORDS);
  localparam int LOW_W  = WRD_W + OFF_W;
  localparam int TAG_W  = ADDR_W - SET_W - LOW_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int CNT_W  = WRD_W + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_DRAIN, S_WBRD, S_WBWAIT, S_WBMEM, S_RFMEM, S_RFPUSH
  } state_t;

  function automatic logic [DATA_W-1:0] tmask(input logic is_tag,
                                              input logic [SET_W-1:0] s,
                                              input logic [WRD_W-1:0] w);
    logic [DATA_W-1:0] t;
    t = DATA_W'({is_tag, s, w}) * DATA_W'(64'h9E37_79B9_7F4A_7C15);
    return KEY ^ t ^ {t[DATA_W/2-1:0], t[DATA_W-1:DATA_W/2]};
  endfunction

  state_t state;
  logic [CNT_W-1:0]  cnt;
  logic              r_we, r_missed, r_refilled;
  logic [TAG_W-1:0]  r_tag, r_vtag;
  logic [SET_W-1:0]  r_set;
  logic [WRD_W-1:0]  r_word;
  logic [BE_W-1:0]   r_be;
  logic [DATA_W-1:0] r_wdata;
  logic [LINE_W-1:0] r_line;

  logic [DATA_W-1:0] dmem [SETS*WORDS];
  logic [DATA_W-1:0] tmem [SETS];
  logic [SETS-1:0]   vld, drt;

  logic unused_bits;
  assign unused_bits = ^req_addr[OFF_W-1:0];

  // scrambling pipeline
  logic [ENC_LAT-1:0] ev;
  logic               et [ENC_LAT];
  logic [SET_W-1:0]   es [ENC_LAT];
  logic [WRD_W-1:0]   ew [ENC_LAT];
  logic [DATA_W-1:0]  ep [ENC_LAT];
  logic [DATA_W-1:0]  ec [ENC_LAT];

  // recovery pipelines
  logic [DEC_LAT-1:0] dv, lv;
  logic [WRD_W-1:0]   dw [DEC_LAT];
  logic [DATA_W-1:0]  dd [DEC_LAT];
  logic [DATA_W-1:0]  td [DEC_LAT];
  logic               f_hit;
  logic [DATA_W-1:0]  f_pt;

  logic               lk_done, hit, iss_look, iss;
  logic [SET_W-1:0]   iss_set;
  logic [WRD_W-1:0]   iss_word;
  logic               fw_hit, pend_set, pend_tag;
  logic [DATA_W-1:0]  fw_pt, cur, merged, d_out, t_out;
  logic               enc_in_v, enc_in_tag;
  logic [WRD_W-1:0]   enc_in_word;
  logic [DATA_W-1:0]  enc_in_pt;

  assign lk_done = lv[DEC_LAT-1];
  assign d_out   = dd[DEC_LAT-1];
  assign t_out   = td[DEC_LAT-1];
  assign hit     = vld[r_set] && (t_out == {{(DATA_W-TAG_W){1'b0}}, r_tag});
  assign cur     = f_hit ? f_pt : d_out;

  always_comb
    for (int b = 0; b < BE_W; b++)
      merged[b*8 +: 8] = (r_we && r_be[b]) ? r_wdata[b*8 +: 8] : cur[b*8 +: 8];

  assign iss_look = (state == S_IDLE && req_valid) || (state == S_DRAIN && ~|ev && r_refilled);
  assign iss      = iss_look || state == S_WBRD;
  assign iss_set  = (state == S_IDLE) ? req_addr[LOW_W +: SET_W] : r_set;
  assign iss_word = (state == S_IDLE) ? req_addr[OFF_W +: WRD_W] :
                    (state == S_WBRD) ? cnt[WRD_W-1:0] : r_word;

  always_comb begin
    fw_hit = 1'b0;
    fw_pt  = '0;
    pend_set = 1'b0;
    pend_tag = 1'b0;
    for (int i = ENC_LAT-1; i >= 0; i--) begin
      if (ev[i] && !et[i] && es[i] == iss_set && ew[i] == iss_word) begin
        fw_hit = 1'b1;
        fw_pt  = ep[i];
      end
      if (ev[i] && es[i] == r_set) pend_set = 1'b1;
      if (ev[i] && et[i]) pend_tag = 1'b1;
    end
  end

  assign enc_in_v    = (state == S_LOOK && lk_done && hit && r_we) || state == S_RFPUSH;
  assign enc_in_tag  = state == S_RFPUSH && cnt == CNT_W'(WORDS);
  assign enc_in_word = (state == S_RFPUSH) ? cnt[WRD_W-1:0] : r_word;
  assign enc_in_pt   = (state != S_RFPUSH) ? merged :
                       enc_in_tag ? {{(DATA_W-TAG_W){1'b0}}, r_tag} :
                       r_line[enc_in_word*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ev <= '0;
      dv <= '0;
      lv <= '0;
    end else begin
      ev <= {ev[ENC_LAT-2:0], enc_in_v};
      dv <= {dv[DEC_LAT-2:0], iss};
      lv <= {lv[DEC_LAT-2:0], iss_look};
    end

  always_ff @(posedge clk) begin
    et[0] <= enc_in_tag;
    es[0] <= r_set;
    ew[0] <= enc_in_word;
    ep[0] <= enc_in_pt;
    ec[0] <= enc_in_pt ^ tmask(enc_in_tag, r_set, enc_in_word);
    for (int i = 1; i < ENC_LAT; i++) begin
      et[i] <= et[i-1];
      es[i] <= es[i-1];
      ew[i] <= ew[i-1];
      ep[i] <= ep[i-1];
      ec[i] <= ec[i-1];
    end
    if (ev[ENC_LAT-1]) begin
      if (et[ENC_LAT-1]) tmem[es[ENC_LAT-1]] <= ec[ENC_LAT-1];
      else dmem[{es[ENC_LAT-1], ew[ENC_LAT-1]}] <= ec[ENC_LAT-1];
    end
  end

  always_ff @(posedge clk) begin
    dd[0] <= dmem[{iss_set, iss_word}] ^ tmask(1'b0, iss_set, iss_word);
    td[0] <= tmem[iss_set] ^ tmask(1'b1, iss_set, '0);
    dw[0] <= iss_word;
    for (int i = 1; i < DEC_LAT; i++) begin
      dd[i] <= dd[i-1];
      td[i] <= td[i-1];
      dw[i] <= dw[i-1];
    end
    if (iss_look) begin
      f_hit <= fw_hit;
      f_pt  <= fw_pt;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0;
      r_we <= 1'b0;
      r_missed <= 1'b0;
      r_refilled <= 1'b0;
      r_tag <= '0;
      r_vtag <= '0;
      r_set <= '0;
      r_word <= '0;
      r_be <= '0;
      r_wdata <= '0;
      r_line <= '0;
      vld <= '0;
      drt <= '0;
      rsp_valid <= 1'b0;
      rsp_hit <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if ((state == S_WBRD || state == S_WBWAIT) && dv[DEC_LAT-1])
        r_line[dw[DEC_LAT-1]*DATA_W +: DATA_W] <= d_out;
      case (state)
        S_IDLE:
          if (req_valid) begin
            r_we <= req_we;
            r_tag <= req_addr[ADDR_W-1 -: TAG_W];
            r_set <= req_addr[LOW_W +: SET_W];
            r_word <= req_addr[OFF_W +: WRD_W];
            r_be <= req_be;
            r_wdata <= req_wdata;
            r_missed <= 1'b0;
            r_refilled <= 1'b0;
            state <= S_LOOK;
          end
        S_LOOK:
          if (lk_done) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_hit <= !r_missed;
              rsp_rdata <= merged;
              if (r_we) drt[r_set] <= 1'b1;
              state <= S_IDLE;
            end else begin
              r_missed <= 1'b1;
              r_vtag <= t_out[TAG_W-1:0];
              state <= (vld[r_set] && drt[r_set]) ? S_DRAIN : S_RFMEM;
            end
          end
        S_DRAIN:
          if (~|ev) begin
            cnt <= '0;
            state <= r_refilled ? S_LOOK : S_WBRD;
          end
        S_WBRD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(WORDS-1)) state <= S_WBWAIT;
        end
        S_WBWAIT:
          if (dv[DEC_LAT-1] && dw[DEC_LAT-1] == WRD_W'(WORDS-1)) state <= S_WBMEM;
        S_WBMEM:
          if (mem_ack) state <= S_RFMEM;
        S_RFMEM:
          if (mem_ack) begin
            r_line <= mem_rline;
            cnt <= '0;
            state <= S_RFPUSH;
          end
        S_RFPUSH: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(WORDS)) begin
            vld[r_set] <= 1'b1;
            drt[r_set] <= 1'b0;
            r_refilled <= 1'b1;
            state <= S_DRAIN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end

  assign ready     = state == S_IDLE;
  assign mem_req   = state == S_WBMEM || state == S_RFMEM;
  assign mem_we    = state == S_WBMEM;
  assign mem_addr  = {(state == S_WBMEM) ? r_vtag : r_tag, r_set, {LOW_W{1'b0}}};
  assign mem_wline = r_line;

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wline));

  p_tag_settled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_look |-> !pend_tag);

  p_refill_no_stale_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_RFMEM |-> !pend_set);

  p_wb_dirty_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> vld[r_set] && drt[r_set]);

  p_rsp_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ready && !mem_req);
endmodule

// File: tb/test_enc_cache_ctrl.sv
`timescale 1ns/1ps
module test_enc_cache_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [63:0] req_addr = '0, req_wdata = '0;
  logic [7:0] req_be = '0;
  logic ready, rsp_valid, rsp_hit, mem_req, mem_we;
  logic [63:0] rsp_rdata, mem_addr;
  logic [255:0] mem_wline;
  logic mem_ack = 1'b0;
  logic [255:0] mem_rline = '0;

  always #4 clk = ~clk;

  enc_cache_ctrl i_enc_cache_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .ready(ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
    .mem_ack(mem_ack), .mem_rline(mem_rline));

  int checks = 0, fails = 0, nwb = 0, nrf = 0;
  logic [63:0] last_wb = '0;
  logic [63:0] ref_mem [logic [63:0]];
  logic [63:0] bmem [logic [63:0]];

  function automatic logic [63:0] init_word(input logic [63:0] wa);
    return {wa[31:0], ~wa[31:0]} ^ 64'h0F1E_2D3C_4B5A_6978;
  endfunction
  function automatic logic [63:0] ref_rd(input logic [63:0] wa);
    return ref_mem.exists(wa) ? ref_mem[wa] : init_word(wa);
  endfunction
  function automatic logic [63:0] bmem_rd(input logic [63:0] wa);
    return bmem.exists(wa) ? bmem[wa] : init_word(wa);
  endfunction
  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] nw,
                                        input logic [7:0] be);
    logic [63:0] m;
    for (int b = 0; b < 8; b++) m[b*8 +: 8] = be[b] ? nw[b*8 +: 8] : old[b*8 +: 8];
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: ack two cycles after request is seen
  initial begin
    int wcnt = 0;
    bit pend = 0;
    logic [63:0] p_addr = '0;
    logic p_we = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ack = 0; wcnt = 0; pend = 0;
      end else if (mem_ack) begin
        mem_ack = 0; pend = 0;
      end else if (mem_req) begin
        if (pend) chk(mem_addr == p_addr && mem_we == p_we, "R11", "held request",
                      mem_addr, p_addr);
        if (!pend) chk(mem_addr[4:0] == 5'd0, "R3", "line aligned address", mem_addr,
                       {mem_addr[63:5], 5'd0});
        pend = 1; p_addr = mem_addr; p_we = mem_we;
        if (wcnt == 2) begin
          wcnt = 0;
          mem_ack = 1;
          if (mem_we) begin
            for (int w = 0; w < 4; w++) bmem[mem_addr + 64'(w*8)] = mem_wline[w*64 +: 64];
            last_wb = mem_addr;
            nwb++;
          end else begin
            for (int w = 0; w < 4; w++) mem_rline[w*64 +: 64] = bmem_rd(mem_addr + 64'(w*8));
            nrf++;
          end
        end else wcnt++;
      end else pend = 0;
    end
  end

  typedef struct packed {
    logic        we;
    logic [63:0] addr;
    logic [7:0]  be;
    logic [63:0] wdata;
    logic        hit;
    logic [1:0]  wbs;
    logic [63:0] wba;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 64'h1070, 8'h00, 64'h0, 1'b0, 2'd0, 64'h0},                    // R2 R3 cold miss
    '{1'b0, 64'h1060, 8'h00, 64'h0, 1'b1, 2'd0, 64'h0},                    // R4 R10
    '{1'b1, 64'h1068, 8'hFF, 64'h1122_3344_5566_7788, 1'b1, 2'd0, 64'h0},  // R5 full
    '{1'b0, 64'h1068, 8'h00, 64'h0, 1'b1, 2'd0, 64'h0},                    // R6 forward
    '{1'b1, 64'h106B, 8'h0F, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 2'd0, 64'h0},  // R1 R5 R6
    '{1'b0, 64'h106D, 8'h00, 64'h0, 1'b1, 2'd0, 64'h0},                    // R1
    '{1'b0, 64'h2068, 8'h00, 64'h0, 1'b0, 2'd1, 64'h1060},                 // R7
    '{1'b0, 64'h1068, 8'h00, 64'h0, 1'b0, 2'd0, 64'h0},                    // R8, R7 data
    '{1'b1, 64'h5138, 8'h81, 64'hA1B2_C3D4_E5F6_0718, 1'b0, 2'd0, 64'h0},  // R9
    '{1'b0, 64'h5138, 8'h00, 64'h0, 1'b1, 2'd0, 64'h0},                    // R9
    '{1'b0, 64'h5120, 8'h00, 64'h0, 1'b1, 2'd0, 64'h0},                    // R10
    '{1'b0, 64'h1120, 8'h00, 64'h0, 1'b0, 2'd1, 64'h5120},                 // R7 R9
    '{1'b0, 64'h5138, 8'h00, 64'h0, 1'b0, 2'd0, 64'h0},                    // R9 data survived
    '{1'b0, 64'h1070, 8'h00, 64'h0, 1'b1, 2'd0, 64'h0}                     // R10
  };

  task automatic run_vec(input vec_t v);
    logic [63:0] wa, exp;
    int wb0, rf0;
    wa = {v.addr[63:3], 3'b000};
    wb0 = nwb; rf0 = nrf;
    while (!ready) @(negedge clk);
    req_valid = 1; req_we = v.we; req_addr = v.addr; req_be = v.be; req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    if (v.we) begin
      exp = merge(ref_rd(wa), v.wdata, v.be);
      ref_mem[wa] = exp;
    end else exp = ref_rd(wa);
    chk(rsp_hit == v.hit, v.hit ? "R4" : "R3", "hit flag", 64'(rsp_hit), 64'(v.hit));
    chk(rsp_rdata == exp, v.we ? "R5" : (v.hit ? "R4" : "R3"), "data", rsp_rdata, exp);
    chk(nrf - rf0 == (v.hit ? 0 : 1), "R3", "refill count", 64'(nrf - rf0), v.hit ? 64'd0 : 64'd1);
    chk(nwb - wb0 == int'(v.wbs), v.wbs != 0 ? "R7" : "R8", "writeback count",
        64'(nwb - wb0), 64'(v.wbs));
    if (v.wbs != 0) chk(last_wb == v.wba, "R7", "writeback address", last_wb, v.wba);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1 && rsp_valid == 0 && mem_req == 0, "R2", "in reset",
        {61'b0, ready, rsp_valid, mem_req}, 64'h4);
    rst_n = 1;
    @(negedge clk);
    chk(ready == 1 && rsp_valid == 0 && mem_req == 0, "R2", "after reset",
        {61'b0, ready, rsp_valid, mem_req}, 64'h4);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R6: two pending writes to one word, youngest wins, and the partial merge sees the older one
    run_vec('{1'b1, 64'h1078, 8'hFF, 64'h1111_2222_3333_4444, 1'b1, 2'd0, 64'h0});
    run_vec('{1'b1, 64'h1078, 8'h0F, 64'h5555_6666_AAAA_BBBB, 1'b1, 2'd0, 64'h0});
    run_vec('{1'b0, 64'h1078, 8'h00, 64'h0, 1'b1, 2'd0, 64'h0});

    // R2: reset drops the modified line; next access is a clean miss
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(ready == 1 && rsp_valid == 0 && mem_req == 0, "R2", "mid-run reset",
        {61'b0, ready, rsp_valid, mem_req}, 64'h4);
    rst_n = 1;
    @(negedge clk);
    run_vec('{1'b0, 64'h1070, 8'h00, 64'h0, 1'b0, 2'd0, 64'h0});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule